// File: doc/BRIEF.md
# Bus Dominant-Pulse Wake Detector

This block watches the receive level of a single-wire bus (1 = recessive, 0 = dominant) and raises a one-cycle wake pulse when a remote node has requested wake-up. A valid request has three parts in order: a falling edge, a dominant phase that lasts at least a minimum number of microsecond ticks, and the rising edge that ends that phase. The pulse is issued on the closing rising edge. It is not issued when the minimum duration is reached.

The raw bus level first passes through a synchroniser. Edge detection, a saturating duration counter and a small sequencer follow it. Duration is measured only while measurement is allowed. In the sleep mode measurement is always allowed. In the normal mode it is allowed only while the local transmit data is high, so a dominant phase that the node drives itself never counts as a wake request. If measurement stops being allowed during a dominant phase, that phase is abandoned, and only a new falling edge can start another measurement.

Top module: `bus_wake_detect`

## Requirements
- R1: While `rst` is high and after it is released with the bus recessive and idle, `wake_pulse` is 0.
- R2: A dominant phase that sees at least `THRESH_TICKS` ticks of `us_tick` while it is measured, followed by a rising edge, yields exactly one `wake_pulse`, and that pulse is high for one clock cycle only.
- R3: A dominant phase that sees `THRESH_TICKS`-1 ticks yields no pulse.
- R4: `wake_pulse` goes high on the third rising clock edge after `bus_rx` rises. Two edges are used by the synchroniser and one by the output register.
- R5: No pulse is produced while the bus stays dominant, however many ticks have passed.
- R6: With `mode_sel` = 0 (sleep), the duration is measured whatever the level of `tx_level`.
- R7: With `mode_sel` = 1 (normal), a dominant phase during which `tx_level` is 0 yields no pulse. With `tx_level` = 1 it is measured normally.
- R8: If measurement is disallowed at any time during a dominant phase, including at its falling edge, that phase yields no pulse, even when measurement is allowed again before the rising edge.
- R9: The duration counter saturates. A dominant phase longer than three times the threshold still yields a pulse on its rising edge.
- R10: Measurement permission is sampled in the same cycle in which the synchronised rising edge is seen. If it is low in that cycle no pulse is produced. If it drops one cycle later, the pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rx | input | 1 | Asynchronous bus receive level, 1 recessive, 0 dominant |
| mode_sel | input | 1 | Operating mode: 0 sleep, 1 normal |
| tx_level | input | 1 | Local transmit data level, synchronous to clk |
| us_tick | input | 1 | One-cycle microsecond time-base strobe |
| wake_pulse | output | 1 | One-cycle wake request indication |

## Verification
Two things can fall in the same clock: the synchronised rising edge that would qualify a wake, and the loss of measurement permission when transmit data goes low in normal mode. The bench creates this coincidence by dropping `tx_level` in exactly the cycle in which the delayed rise reaches the sequencer, and expects no pulse. It then repeats the run with the drop one cycle later and expects a pulse. This shows that permission is judged together with the rise, and not before or after it.

// File: rtl/bus_wake_pkg.sv
package bus_wake_pkg;

    typedef enum logic [1:0] {
        WK_IDLE    = 2'd0,
        WK_TIMING  = 2'd1,
        WK_BLOCKED = 2'd2
    } wk_state_e;

    typedef enum logic {
        MODE_SLEEP  = 1'b0,
        MODE_NORMAL = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_evt_t;

    function automatic logic meas_allowed(input op_mode_e m, input logic tx);
        return (m == MODE_SLEEP) || tx;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/bus_wake_sync.sv
module bus_wake_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= d_async;
            end
            assign d_sync = q;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d_async};
            end
            assign d_sync = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bus_wake_edge.sv
module bus_wake_edge
    import bus_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level,
    output edge_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level;
    end

    always_comb begin
        evt.fall = prev_q & ~level;
        evt.rise = ~prev_q & level;
    end
endmodule

// File: rtl/bus_wake_timer.sv
module bus_wake_timer
    import bus_wake_pkg::*;
#(
    parameter int LIMIT = 80,
    parameter int CW    = cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          met
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !run)               cnt <= '0;
        else if (tick && (cnt != TOP)) cnt <= cnt + 1'b1;
    end

    assign met = (cnt == TOP);
endmodule

// File: rtl/bus_wake_seq.sv
module bus_wake_seq
    import bus_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_evt_t evt,
    input  logic      meas_ok,
    input  logic      dur_met,
    output wk_state_e state,
    output logic      pulse
);
    wk_state_e nxt;
    logic      fire;

    always_comb begin
        nxt  = state;
        fire = 1'b0;
        unique case (state)
            WK_IDLE: begin
                if (evt.fall) nxt = meas_ok ? WK_TIMING : WK_BLOCKED;
            end
            WK_TIMING: begin
                if (evt.rise) begin
                    nxt  = WK_IDLE;
                    fire = meas_ok && dur_met;
                end else if (!meas_ok) begin
                    nxt = WK_BLOCKED;
                end
            end
            WK_BLOCKED: begin
                if (evt.rise) nxt = WK_IDLE;
            end
            default: nxt = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WK_IDLE;
            pulse <= 1'b0;
        end else begin
            state <= nxt;
            pulse <= fire;
        end
    end
endmodule

// File: rtl/bus_wake_detect.sv
module bus_wake_detect
    import bus_wake_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int THRESH_TICKS = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_rx,
    input  logic mode_sel,
    input  logic tx_level,
    input  logic us_tick,
    output logic wake_pulse
);
    localparam int CNT_W = cnt_width(THRESH_TICKS);

    logic             bus_s;
    edge_evt_t        evt;
    logic             meas_en;
    logic             dur_met;
    logic [CNT_W-1:0] dur_cnt;
    wk_state_e        state;

    assign meas_en = meas_allowed(op_mode_e'(mode_sel), tx_level);

    bus_wake_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d_async(bus_rx), .d_sync(bus_s)
    );

    bus_wake_edge u_edge (
        .clk(clk), .rst(rst), .level(bus_s), .evt(evt)
    );

    bus_wake_timer #(.LIMIT(THRESH_TICKS), .CW(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .run(state == WK_TIMING), .tick(us_tick),
        .cnt(dur_cnt), .met(dur_met)
    );

    bus_wake_seq u_seq (
        .clk(clk), .rst(rst), .evt(evt), .meas_ok(meas_en),
        .dur_met(dur_met), .state(state), .pulse(wake_pulse)
    );
endmodule

// File: rtl/bus_wake_checker.sv
module bus_wake_checker #(
    parameter int CW    = 7,
    parameter int LIMIT = 80
) (
    input logic          clk,
    input logic          rst,
    input logic          wake_pulse,
    input logic          rise_seen,
    input logic          meas_ok,
    input logic          dur_met,
    input logic [CW-1:0] dur_cnt
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse); // R2

    AST_PULSE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(dur_met)); // R3

    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(rise_seen)); // R5

    AST_PULSE_PERMITTED: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(meas_ok)); // R10

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        dur_cnt <= CW'(LIMIT)); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dur_cnt != '0) |=> ((dur_cnt >= $past(dur_cnt)) || (dur_cnt == '0))); // R9
endmodule

bind bus_wake_detect bus_wake_checker #(.CW(CNT_W), .LIMIT(THRESH_TICKS)) u_chk (
    .clk(clk), .rst(rst), .wake_pulse(wake_pulse), .rise_seen(evt.rise),
    .meas_ok(meas_en), .dur_met(dur_met), .dur_cnt(dur_cnt)
);

// File: tb/tb_bus_wake_detect.sv
module tb_bus_wake_detect;
    localparam int TH = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rx = 1'b1;
    logic mode_sel = 1'b0;
    logic tx_level = 1'b1;
    logic us_tick = 1'b0;
    logic wake_pulse;

    int checks = 0;
    int failures = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    bus_wake_detect #(.SYNC_STAGES(2), .THRESH_TICKS(TH)) dut (
        .clk(clk), .rst(rst), .bus_rx(bus_rx), .mode_sel(mode_sel),
        .tx_level(tx_level), .us_tick(us_tick), .wake_pulse(wake_pulse)
    );

    always @(negedge clk) if (!rst && wake_pulse) pulses++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            step(1);
            us_tick = 1'b0;
            step(1);
        end
    endtask

    task automatic low_phase(input int n);
        bus_rx = 1'b0;
        step(4);
        give_ticks(n);
        bus_rx = 1'b1;
        step(6);
    endtask

    task automatic t_reset();
        step(1);
        chk("R1 pulse during reset", wake_pulse, 0);
        step(3);
        rst = 1'b0;
        step(10);
        chk("R1 pulses after reset", pulses, 0);
    endtask

    task automatic t_threshold();
        int p0;
        mode_sel = 1'b0; tx_level = 1'b1;
        p0 = pulses; low_phase(TH - 1);
        chk("R3 one tick short", pulses - p0, 0);
        p0 = pulses; low_phase(TH);
        chk("R2 exactly threshold", pulses - p0, 1);
        p0 = pulses; low_phase(TH + 1);
        chk("R2 one tick over", pulses - p0, 1);
    endtask

    task automatic t_timing();
        int p0;
        mode_sel = 1'b0; tx_level = 1'b1;
        p0 = pulses;
        bus_rx = 1'b0;
        step(4);
        give_ticks(TH + 4);
        step(8);
        chk("R5 no pulse while dominant", pulses - p0, 0);
        bus_rx = 1'b1;
        step(2);
        chk("R4 not yet after two edges", wake_pulse, 0);
        step(1);
        chk("R4 high on third edge", wake_pulse, 1);
        step(1);
        chk("R2 single cycle", wake_pulse, 0);
        step(4);
    endtask

    task automatic t_modes();
        int p0;
        mode_sel = 1'b0; tx_level = 1'b0;
        p0 = pulses; low_phase(TH + 2);
        chk("R6 sleep ignores tx low", pulses - p0, 1);
        mode_sel = 1'b1; tx_level = 1'b0;
        p0 = pulses; low_phase(TH + 2);
        chk("R7 normal tx low blocks", pulses - p0, 0);
        tx_level = 1'b1;
        p0 = pulses; low_phase(TH + 2);
        chk("R7 normal tx high measures", pulses - p0, 1);
    endtask

    task automatic t_abort();
        int p0;
        mode_sel = 1'b1; tx_level = 1'b1;
        p0 = pulses;
        bus_rx = 1'b0;
        step(4);
        give_ticks(40);
        tx_level = 1'b0;
        step(2);
        tx_level = 1'b1;
        give_ticks(TH + 5);
        bus_rx = 1'b1;
        step(6);
        chk("R8 mid-phase drop aborts", pulses - p0, 0);
        p0 = pulses;
        tx_level = 1'b0;
        bus_rx = 1'b0;
        step(4);
        tx_level = 1'b1;
        give_ticks(TH + 5);
        bus_rx = 1'b1;
        step(6);
        chk("R8 disallowed at fall", pulses - p0, 0);
        p0 = pulses; low_phase(TH);
        chk("R8 fresh fall measures", pulses - p0, 1);
    endtask

    task automatic t_saturate();
        int p0;
        mode_sel = 1'b0; tx_level = 1'b1;
        p0 = pulses; low_phase(3 * TH + 20);
        chk("R9 long phase qualifies", pulses - p0, 1);
    endtask

    task automatic t_same_cycle();
        int p0;
        mode_sel = 1'b1; tx_level = 1'b1;
        p0 = pulses;
        bus_rx = 1'b0;
        step(4);
        give_ticks(TH + 3);
        bus_rx = 1'b1;
        step(2);
        tx_level = 1'b0;
        step(1);
        tx_level = 1'b1;
        step(4);
        chk("R10 drop with rise", pulses - p0, 0);
        p0 = pulses;
        bus_rx = 1'b0;
        step(4);
        give_ticks(TH + 3);
        bus_rx = 1'b1;
        step(3);
        tx_level = 1'b0;
        step(1);
        tx_level = 1'b1;
        step(4);
        chk("R10 drop after rise", pulses - p0, 1);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_timing();
        t_modes();
        t_abort();
        t_saturate();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule